// File: doc/BRIEF.md
# Server Watchdog Timer

This block is a countdown watchdog for a server board. Software programs an interval in whole seconds. An internal prescaler turns the system clock into a one-second tick, and a down-counter spends one interval after each start. If the counter reaches zero before software reloads it, the block takes one of two actions. The first is a single-cycle system reset request. The second is a power-off request that stays asserted until power is removed.

An enable strap decides whether the block can run at all. Software cannot override the strap. While the strap is high, software starts, stops, resumes and reloads the countdown through two 32-bit registers: a control/status register and a count register.

A fired flag records that the last system reset came from an expiry. This flag sits on power-on reset only, so it survives the reset the block itself requests. A configuration input can make the countdown start by itself once the board signals that power-on self test has finished.

Top module: `srv_wdog`

## Requirements
- R1: After power-on reset the control/status read value has bit 0 equal to the strap and all other bits 0. The count read value shows the default interval (DEF_SECS) in bits [CNT_W-1:0] and 0 in bits [31:16]. Both action outputs are low.
- R2: Writing 1 to control bit 7 (the trigger) while the strap is high loads the current count from the interval field and sets running (bit 1). Expiry happens exactly N*TICKS_PER_SEC clock edges after the write edge, where N is the interval.
- R3: When the action select (control bit 2) is 0, expiry produces a `sys_reset_req` pulse exactly one cycle long. Expiry also clears running, sets fired (bit 3) and leaves the current count at 0.
- R4: When the action select is 1, expiry raises `pwr_off_req`. The request stays high through system resets until power-on reset, and fired is not set.
- R5: Fired is unaffected by `sys_rst_n`. It is cleared by `por_n` or by writing 1 to control bit 3. Writing 0 to bit 3 leaves it unchanged.
- R6: Writing control with bit 1 = 0 and bit 7 = 0 halts the countdown, and the current count holds its value. Writing bit 1 = 1 resumes from the held count with a full first second.
- R7: While the strap is low, control bit 0 reads 0 and running is forced to 0. Writes of the run and trigger bits are ignored, the current count does not move and no action is taken.
- R8: When `cfg_boot_run` is high, the block stays stopped after reset until `post_done` is high. It then loads the interval and runs. When `cfg_boot_run` is low, `post_done` has no effect.
- R9: A register write is visible on the read ports in the cycle after its write edge.
- R10: An interval field of 0 is treated as 1 second when loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low; clears everything including fired and power-off |
| sys_rst_n | input | 1 | System reset, active low; clears all state except fired and power-off |
| strap_en | input | 1 | Enable strap, high enables the watchdog |
| cfg_boot_run | input | 1 | High: start counting by itself once self test completes |
| post_done | input | 1 | High when power-on self test has completed |
| wr_en | input | 1 | Register write strobe, single cycle |
| wr_sel | input | 1 | 0 selects control/status, 1 selects count |
| wr_data | input | 32 | Write data |
| ctrl_rd | output | 32 | Control/status: bit0 enabled, bit1 running, bit2 action, bit3 fired, bit7 trigger (reads 0) |
| count_rd | output | 32 | Count: interval in [CNT_W-1:0], current count in [16+CNT_W-1:16] |
| sys_reset_req | output | 1 | One-cycle system reset request on expiry |
| pwr_off_req | output | 1 | Power-off request, held until power-on reset |

## Verification
The countdown is started three ways: by trigger writes with intervals of 5, 3 and 0 seconds, by a stop followed by a resume partway through an interval, and by the self-test input in boot-run mode. Each start predicts the exact expiry edge, which tells a correct load value and prescaler phase apart from an off-by-one in either. Restart and shutdown expiries are separated by which output moves and by the state of fired. A system reset placed after each expiry shows which state lives in the power-on domain. A run of trigger writes with the strap low must leave the count frozen and produce no event.

// File: rtl/srv_wdog.sv
module srv_wdog #(
  parameter int unsigned TICKS_PER_SEC = 100_000_000,
  parameter int unsigned CNT_W         = 16,
  parameter int unsigned DEF_SECS      = 300
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        sys_rst_n,
  input  logic        strap_en,
  input  logic        cfg_boot_run,
  input  logic        post_done,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] ctrl_rd,
  output logic [31:0] count_rd,
  output logic        sys_reset_req,
  output logic        pwr_off_req
);
  localparam int PRE_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_SEC - 1);
  localparam int B_EN = 0, B_RUN = 1, B_ACT = 2, B_FIRED = 3, B_TRIG = 7;

  wire rst_n = por_n & sys_rst_n;
  wire unused_wr = ^wr_data;

  logic             running, action, boot_pend, fired, pwr_off_q, rst_pulse;
  logic [CNT_W-1:0] reload, cur;
  logic [PRE_W-1:0] pre;

  wire wr_ctrl = wr_en & ~wr_sel;
  wire wr_cnt  = wr_en &  wr_sel;

  wire [CNT_W-1:0] load_val = (reload == '0) ? CNT_W'(1) : reload;

  wire sw_trig = wr_ctrl & wr_data[B_TRIG] & strap_en;
  wire sw_run  = wr_ctrl & wr_data[B_RUN] & ~wr_data[B_TRIG] & strap_en & ~running;
  wire sw_stop = wr_ctrl & ~wr_data[B_RUN] & ~wr_data[B_TRIG];
  wire boot_go = boot_pend & cfg_boot_run & post_done & strap_en;
  wire start   = sw_trig | boot_go;
  wire tick    = running & (pre == PRE_LAST);
  wire expire  = tick & (cur == CNT_W'(1)) & ~start & strap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      action    <= 1'b0;
      boot_pend <= 1'b1;
      reload    <= CNT_W'(DEF_SECS);
      cur       <= '0;
      pre       <= '0;
      rst_pulse <= 1'b0;
    end else begin
      rst_pulse <= expire & ~action;
      if (wr_cnt)  reload <= wr_data[CNT_W-1:0];
      if (wr_ctrl) action <= wr_data[B_ACT];
      if (start | sw_run) boot_pend <= 1'b0;
      if (!strap_en) begin
        running <= 1'b0;
      end else if (start) begin
        running <= 1'b1;
        cur     <= load_val;
        pre     <= '0;
      end else if (sw_run) begin
        running <= 1'b1;
        pre     <= '0;
        if (cur == '0) cur <= load_val;
      end else if (expire) begin
        running <= 1'b0;
        cur     <= '0;
        pre     <= '0;
      end else begin
        if (sw_stop) running <= 1'b0;
        if (tick) begin
          cur <= cur - 1'b1;
          pre <= '0;
        end else if (running) begin
          pre <= pre + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      fired     <= 1'b0;
      pwr_off_q <= 1'b0;
    end else begin
      if (expire & action) pwr_off_q <= 1'b1;
      if (expire & ~action)                    fired <= 1'b1;
      else if (wr_ctrl & wr_data[B_FIRED])     fired <= 1'b0;
    end
  end

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[B_EN]    = strap_en;
    ctrl_rd[B_RUN]   = running;
    ctrl_rd[B_ACT]   = action;
    ctrl_rd[B_FIRED] = fired;
    count_rd                 = '0;
    count_rd[CNT_W-1:0]      = reload;
    count_rd[16 +: CNT_W]    = cur;
  end

  assign sys_reset_req = rst_pulse;
  assign pwr_off_req   = pwr_off_q;

  assert_one_cycle_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |=> !sys_reset_req);
  assert_fired_with_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> fired);
  assert_hold_off_R4: assert property (@(posedge clk) disable iff (!por_n)
    pwr_off_req |=> pwr_off_req);
  assert_disabled_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_en |=> !running);
  assert_stopped_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !wr_en && !post_done) |=> $stable(cur));
  assert_boot_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !post_done && !wr_en) |=> !running);
endmodule

// File: tb/srv_wdog_test.sv
`timescale 1ns/1ps
module srv_wdog_test;
  localparam int T = 4;
  localparam int DEF = 5;

  logic clk = 0;
  logic por_n = 0, sys_rst_n = 0, strap_en = 1, cfg_boot_run = 0, post_done = 0;
  logic wr_en = 0, wr_sel = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] ctrl_rd, count_rd;
  logic sys_reset_req, pwr_off_req;

  int nchk = 0, nfail = 0, cyc = 0;
  int exp_kind[$];
  int exp_cyc[$];
  logic pwr_prev = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  srv_wdog #(.TICKS_PER_SEC(T), .CNT_W(16), .DEF_SECS(DEF)) uut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .strap_en(strap_en),
    .cfg_boot_run(cfg_boot_run), .post_done(post_done), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .ctrl_rd(ctrl_rd), .count_rd(count_rd),
    .sys_reset_req(sys_reset_req), .pwr_off_req(pwr_off_req));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic push(input int kind, input int at);
    exp_kind.push_back(kind);
    exp_cyc.push_back(at);
  endtask

  task automatic trig_expect(input logic shut, input int secs);
    wr(0, 32'h80 | (32'(shut) << 2));
    push(shut ? 1 : 0, cyc + secs * T);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected expiry events as the design produces them
  always @(negedge clk) begin
    if (sys_reset_req || (pwr_off_req && !pwr_prev)) begin
      nchk++;
      if (exp_kind.size() == 0) begin
        nfail++;
        $display("FAIL R2 unexpected event actual=%0d expected=none", cyc);
      end else begin
        int k, c;
        k = exp_kind.pop_front();
        c = exp_cyc.pop_front();
        if (k != (pwr_off_req && !pwr_prev ? 1 : 0) || c != cyc) begin
          nfail++;
          $display("FAIL R2/R3/R4 event kind/cycle actual=%0d/%0d expected=%0d/%0d",
                   pwr_off_req && !pwr_prev, cyc, k, c);
        end
      end
    end
    pwr_prev <= pwr_off_req;
  end

  initial begin
    repeat (200_000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int k0, k1, k2, cs, hold;
    wait_n(3);
    por_n = 1; sys_rst_n = 1;
    wait_n(1);
    chk("R1 ctrl", ctrl_rd, 32'h1);
    chk("R1 count", count_rd, 32'(DEF));
    chk("R1 outputs", {30'b0, sys_reset_req, pwr_off_req}, 32'h0);
    post_done = 1; wait_n(3);
    chk("R8 post_done ignored without boot-run", 32'(ctrl_rd[1]), 0);
    post_done = 0;

    // R2/R3 restart expiry
    trig_expect(0, DEF);
    chk("R9 running visible", 32'(ctrl_rd[1]), 1);
    chk("R2 current loaded", 32'(count_rd[31:16]), 32'(DEF));
    wait_n(DEF * T + 2);
    chk("R3 fired set", 32'(ctrl_rd[3]), 1);
    chk("R3 running cleared", 32'(ctrl_rd[1]), 0);
    chk("R3 count at zero", 32'(count_rd[31:16]), 0);
    @(negedge clk) sys_rst_n = 0;
    @(negedge clk) sys_rst_n = 1;
    wait_n(1);
    chk("R5 fired survives system reset", 32'(ctrl_rd[3]), 1);
    wr(0, 32'h0);
    chk("R5 write 0 keeps fired", 32'(ctrl_rd[3]), 1);
    wr(0, 32'h8);
    chk("R5 write 1 clears fired", 32'(ctrl_rd[3]), 0);

    // R4 shutdown expiry
    wr(1, 32'd3);
    chk("R9 interval visible", count_rd[15:0], 3);
    trig_expect(1, 3);
    wait_n(3 * T + 3);
    chk("R4 power-off raised", 32'(pwr_off_req), 1);
    chk("R4 fired not set", 32'(ctrl_rd[3]), 0);
    @(negedge clk) sys_rst_n = 0;
    @(negedge clk) sys_rst_n = 1;
    wait_n(1);
    chk("R4 power-off survives system reset", 32'(pwr_off_req), 1);
    @(negedge clk) por_n = 0;
    @(negedge clk) por_n = 1;
    wait_n(1);
    chk("R4 power-off cleared by power-on reset", 32'(pwr_off_req), 0);

    // R6 stop and resume
    wr(1, 32'd6);
    wr(0, 32'h80);
    k0 = cyc;
    wait_n(9);
    wr(0, 32'h0);
    k1 = cyc;
    cs = 6 - (k1 - k0) / T;
    chk("R6 held count", 32'(count_rd[31:16]), 32'(cs));
    chk("R6 stopped", 32'(ctrl_rd[1]), 0);
    wait_n(20);
    chk("R6 count frozen", 32'(count_rd[31:16]), 32'(cs));
    wr(0, 32'h2);
    k2 = cyc;
    push(0, k2 + cs * T);
    wait_n(cs * T + 3);
    wr(0, 32'h8);

    // R7 strap low
    wr(0, 32'h80);
    wait_n(5);
    @(negedge clk) strap_en = 0;
    wait_n(1);
    chk("R7 enabled reads 0", 32'(ctrl_rd[0]), 0);
    chk("R7 running forced 0", 32'(ctrl_rd[1]), 0);
    hold = int'(count_rd[31:16]);
    wr(0, 32'h82);
    chk("R7 trigger ignored", 32'(ctrl_rd[1]), 0);
    wait_n(40);
    chk("R7 count frozen", 32'(count_rd[31:16]), 32'(hold));
    @(negedge clk) strap_en = 1;
    wait_n(1);
    chk("R7 stays stopped on re-enable", 32'(ctrl_rd[1]), 0);

    // R8 boot in running
    cfg_boot_run = 1;
    @(negedge clk) sys_rst_n = 0;
    @(negedge clk) sys_rst_n = 1;
    wait_n(10);
    chk("R8 waits for self test", 32'(ctrl_rd[1]), 0);
    post_done = 1;
    @(negedge clk);
    post_done = 0;
    push(0, cyc + DEF * T);
    chk("R8 started after self test", 32'(ctrl_rd[1]), 1);
    chk("R8 loaded interval", 32'(count_rd[31:16]), 32'(DEF));
    wait_n(DEF * T + 3);
    cfg_boot_run = 0;
    wr(0, 32'h8);

    // R10 zero interval
    wr(1, 32'd0);
    trig_expect(0, 1);
    chk("R10 zero loads one", 32'(count_rd[31:16]), 1);
    wait_n(T + 4);

    chk("R2 all expected events seen", 32'(exp_kind.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule